// File: doc/BRIEF.md
# Integer ALU with Condition Evaluation

This block is the arithmetic and logic core of an execution unit. Each cycle it takes a left and a right operand, a 4-bit operation code and a 4-bit condition select. One clock edge later it presents the result word, one condition bit and a select line. The select line hands field operations to a separate unit.

The block keeps a single carry/borrow flag from one operation to the next, so multi-word sums and differences can be chained. The conditions are built from the adder's carry-out, the most significant bits of the two adder inputs and the result word. They cover signed comparison, overflow, zero, bounds checking and a test on the top three result bits. Every clock cycle is one operation. The OR code with zero operands serves as an idle cycle that leaves the flag alone.

Top module: `eu_alu`

## Requirements
- R1: Opcode 0 gives left OR right, opcode 1 gives left AND right, and opcode 8 gives left XOR right.
- R2: Opcodes 2, 6, 12 and 14 give left + right, and opcodes 7, 13 and 15 give left − right. These ignore the flag and wrap modulo 2^W.
- R3: Every add and subtract opcode (2, 4, 5, 6, 7, 12, 13, 14, 15) writes the flag. An add stores its carry-out, and a subtract stores its borrow (the inverse of the adder carry-out). Opcode 4 gives left + right + flag, and opcode 5 gives left − right − flag. Opcodes 0, 1, 3, 8, 9, 10 and 11 leave the flag unchanged.
- R4: Opcode 3 (bounds check) returns the left operand and does not write the flag. For this opcode the adder forms right − left. Condition select 5 is true when left is greater than right, taken as unsigned, and select 13 is its complement.
- R5: The result, condition and field select are registered and change one clock edge after the inputs are presented. Reset clears all three outputs and the flag. The reset takes effect at once and is released in step with the clock.
- R6: Condition select 4 gives the overflow cout ^ a[MSB] ^ b[MSB] ^ sum[MSB], where a and b are the adder inputs (the right operand is inverted for a subtract). Select 12 is its complement.
- R7: Condition select 2 (less than zero) gives cout ^ a[MSB] ^ b[MSB], and select 10 (greater or equal) is its complement.
- R8: Condition select 1 is true when the result is all zeros, and select 9 is its complement.
- R9: Condition select 3 is zero OR less-than-zero, and select 11 (greater than zero) is its complement.
- R10: Condition select 6 is true when the three most significant result bits are not all equal, and select 14 is its complement.
- R11: Condition selects 0, 7, 8 and 15 always give false.
- R12: Opcode 10 sets the field select output for one cycle and gives a zero result. Opcodes 9 and 11 give a zero result, and every other opcode clears the field select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lhs | input | W | Left operand |
| rhs | input | W | Right operand |
| opcode | input | 4 | Operation code |
| cond_sel | input | 4 | Condition select |
| result | output | W | Registered result |
| cond_out | output | 1 | Registered condition bit |
| field_sel | output | 1 | Registered select for the external field unit |

## Verification
The hardest state to reach from the ports is a known value of the hidden flag at the moment a carry-chained add or subtract runs. No output shows the flag directly. The stimulus table is therefore ordered so that each chained operation comes straight after a plain operation whose carry or borrow is known. A flag-neutral logic opcode and a bounds check are placed between a flag-setting operation and a chained add, which shows that those opcodes preserve the flag. A mid-run reset is followed by a chained add of zeros, which brings the cleared flag out on the result.

// File: rtl/eu_alu_pkg.sv
package eu_alu_pkg;

  localparam int OPW = 4;
  localparam int CSW = 4;

  typedef enum logic [OPW-1:0] {
    OP_OR    = 4'd0,
    OP_AND   = 4'd1,
    OP_ADDV2 = 4'd2,
    OP_BOUND = 4'd3,
    OP_ADDC  = 4'd4,
    OP_SUBC  = 4'd5,
    OP_ADDL  = 4'd6,
    OP_SUBL  = 4'd7,
    OP_XOR   = 4'd8,
    OP_RSV9  = 4'd9,
    OP_FIELD = 4'd10,
    OP_RSV11 = 4'd11,
    OP_ADDV  = 4'd12,
    OP_SUBV  = 4'd13,
    OP_ADDU  = 4'd14,
    OP_SUBU  = 4'd15
  } alu_op_e;

  typedef enum logic [CSW-1:0] {
    CS_FALSE   = 4'd0,
    CS_ZERO    = 4'd1,
    CS_NEG     = 4'd2,
    CS_LEQ     = 4'd3,
    CS_OVF     = 4'd4,
    CS_OOB     = 4'd5,
    CS_TOPMIX  = 4'd6,
    CS_RSV7    = 4'd7,
    CS_RSV8    = 4'd8,
    CS_NZERO   = 4'd9,
    CS_GEQ     = 4'd10,
    CS_GTZ     = 4'd11,
    CS_NOVF    = 4'd12,
    CS_INB     = 4'd13,
    CS_TOPSAME = 4'd14,
    CS_RSV15   = 4'd15
  } cond_sel_e;

  typedef enum logic [1:0] {SRC_ZERO, SRC_ADDER, SRC_LOGIC, SRC_LEFT} res_src_e;
  typedef enum logic [1:0] {LF_OR, LF_AND, LF_XOR} logic_fn_e;

  typedef struct packed {
    logic      arith;   // writes the flag
    logic      sub;     // invert right operand, store borrow
    logic      chain;   // consume the flag
    logic      bound;   // adder forms right - left
    logic      fsel;    // hand off to field unit
    res_src_e  src;
    logic_fn_e fn;
  } alu_ctl_t;

endpackage

// File: rtl/eu_alu_rst_sync.sv
module eu_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/eu_alu_decode.sv
module eu_alu_decode
  import eu_alu_pkg::*;
(
  input  alu_op_e  op,
  output alu_ctl_t ctl
);

  always_comb begin
    ctl = '{arith: 1'b0, sub: 1'b0, chain: 1'b0, bound: 1'b0,
            fsel: 1'b0, src: SRC_ZERO, fn: LF_OR};
    case (op)
      OP_OR:    begin ctl.src = SRC_LOGIC; ctl.fn = LF_OR;  end
      OP_AND:   begin ctl.src = SRC_LOGIC; ctl.fn = LF_AND; end
      OP_XOR:   begin ctl.src = SRC_LOGIC; ctl.fn = LF_XOR; end
      OP_BOUND: begin ctl.src = SRC_LEFT;  ctl.bound = 1'b1; end
      OP_FIELD: ctl.fsel = 1'b1;
      OP_ADDV2, OP_ADDL, OP_ADDV, OP_ADDU: begin
        ctl.arith = 1'b1; ctl.src = SRC_ADDER;
      end
      OP_ADDC: begin
        ctl.arith = 1'b1; ctl.chain = 1'b1; ctl.src = SRC_ADDER;
      end
      OP_SUBL, OP_SUBV, OP_SUBU: begin
        ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.src = SRC_ADDER;
      end
      OP_SUBC: begin
        ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.chain = 1'b1; ctl.src = SRC_ADDER;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/eu_alu_adder.sv
module eu_alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
  end

endmodule

// File: rtl/eu_alu_cond.sv
module eu_alu_cond
  import eu_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  cond_sel_e    sel,
  input  logic         cout,
  input  logic         a_msb,
  input  logic         b_msb,
  input  logic [W-1:0] res,
  input  logic         sum_msb,
  output logic         cond
);

  localparam int TOP = 3;

  logic neg, ovf, zero, topmix;

  always_comb begin
    neg    = cout ^ a_msb ^ b_msb;
    ovf    = neg ^ sum_msb;
    zero   = (res == '0);
    topmix = !((res[W-1 -: TOP] == '0) || (res[W-1 -: TOP] == '1));
    case (sel)
      CS_ZERO:    cond = zero;
      CS_NZERO:   cond = !zero;
      CS_NEG:     cond = neg;
      CS_GEQ:     cond = !neg;
      CS_LEQ:     cond = zero | neg;
      CS_GTZ:     cond = !(zero | neg);
      CS_OVF:     cond = ovf;
      CS_NOVF:    cond = !ovf;
      CS_OOB:     cond = !cout;
      CS_INB:     cond = cout;
      CS_TOPMIX:  cond = topmix;
      CS_TOPSAME: cond = !topmix;
      default:    cond = 1'b0;
    endcase
  end

endmodule

// File: rtl/eu_alu.sv
module eu_alu
  import eu_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic [3:0]   opcode,
  input  logic [3:0]   cond_sel,
  output logic [W-1:0] result,
  output logic         cond_out,
  output logic         field_sel
);

  localparam int MSB = W - 1;

  logic         rst_q_n;
  alu_ctl_t     ctl;
  logic [W-1:0] a_op, b_op, sum, logic_res, res_d;
  logic         cin, cout, cond_d, carry_q, carry_d, carry_en;

  eu_alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  eu_alu_decode u_dec (
    .op(alu_op_e'(opcode)), .ctl(ctl)
  );

  // operand steering into the single adder
  always_comb begin
    a_op = lhs;
    b_op = rhs;
    cin  = 1'b0;
    if (ctl.bound) begin
      a_op = rhs;
      b_op = ~lhs;
      cin  = 1'b1;
    end else if (ctl.sub) begin
      b_op = ~rhs;
      cin  = ctl.chain ? ~carry_q : 1'b1;
    end else begin
      cin  = ctl.chain ? carry_q : 1'b0;
    end
  end

  eu_alu_adder #(.W(W)) u_add (
    .a(a_op), .b(b_op), .cin(cin), .sum(sum), .cout(cout)
  );

  always_comb begin
    case (ctl.fn)
      LF_AND:  logic_res = lhs & rhs;
      LF_XOR:  logic_res = lhs ^ rhs;
      default: logic_res = lhs | rhs;
    endcase
    case (ctl.src)
      SRC_ADDER: res_d = sum;
      SRC_LOGIC: res_d = logic_res;
      SRC_LEFT:  res_d = lhs;
      default:   res_d = '0;
    endcase
    carry_en = ctl.arith;
    carry_d  = ctl.sub ? ~cout : cout;
  end

  eu_alu_cond #(.W(W)) u_cond (
    .sel(cond_sel_e'(cond_sel)), .cout(cout), .a_msb(a_op[MSB]),
    .b_msb(b_op[MSB]), .res(res_d), .sum_msb(sum[MSB]), .cond(cond_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result    <= '0;
      cond_out  <= 1'b0;
      field_sel <= 1'b0;
      carry_q   <= 1'b0;
    end else begin
      result    <= res_d;
      cond_out  <= cond_d;
      field_sel <= ctl.fsel;
      if (carry_en) carry_q <= carry_d;
    end
  end

endmodule

// File: rtl/eu_alu_chk.sv
module eu_alu_chk
  import eu_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic [W-1:0] lhs,
  input logic [W-1:0] rhs,
  input logic [3:0]   opcode,
  input logic [3:0]   cond_sel,
  input logic [W-1:0] result,
  input logic         cond_out,
  input logic         field_sel,
  input logic         carry_q
);

  AST_LOGIC_OR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (opcode == OP_OR) |=> (result == ($past(lhs) | $past(rhs)))); // R1

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (opcode inside {OP_OR, OP_AND, OP_XOR, OP_BOUND, OP_FIELD, OP_RSV9, OP_RSV11})
    |=> $stable(carry_q)); // R3

  AST_BOUND_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (opcode == OP_BOUND) |=> (result == $past(lhs))); // R4

  AST_ZERO_COND: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cond_sel == CS_ZERO) |=> (cond_out == (result == '0))); // R8

  AST_TOP_MIX: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cond_sel == CS_TOPMIX) |=>
    (cond_out == !((result[W-1 -: 3] == 3'b000) || (result[W-1 -: 3] == 3'b111)))); // R10

  AST_SEL_FALSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cond_sel inside {CS_FALSE, CS_RSV7, CS_RSV8, CS_RSV15}) |=> !cond_out); // R11

  AST_FIELD_ON: assert property (@(posedge clk) disable iff (!rst_q_n)
    (opcode == OP_FIELD) |=> (field_sel && (result == '0))); // R12

  AST_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_q_n)
    (opcode != OP_FIELD) |=> !field_sel); // R12

endmodule

bind eu_alu eu_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .lhs(lhs), .rhs(rhs), .opcode(opcode),
  .cond_sel(cond_sel), .result(result), .cond_out(cond_out),
  .field_sel(field_sel), .carry_q(carry_q)
);

// File: tb/eu_alu_bench.sv
module eu_alu_bench;

  localparam int W  = 32;
  localparam int NV = 55;

  typedef struct packed {
    logic [3:0]   op;
    logic [3:0]   sel;
    logic [W-1:0] l;
    logic [W-1:0] r;
    logic [W-1:0] res;
    logic         cnd;
    logic         fu;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd14, 4'd4,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 1'b0},
    '{4'd14, 4'd4,  32'h7FFFFFFF, 32'h00000000, 32'h7FFFFFFF, 1'b0, 1'b0},
    '{4'd3,  4'd5,  32'h00000000, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
    '{4'd3,  4'd5,  32'h00000002, 32'h00000001, 32'h00000002, 1'b1, 1'b0},
    '{4'd3,  4'd13, 32'h00000000, 32'h00000001, 32'h00000000, 1'b1, 1'b0},
    '{4'd3,  4'd13, 32'h00000002, 32'h00000001, 32'h00000002, 1'b0, 1'b0},
    '{4'd15, 4'd2,  32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{4'd14, 4'd2,  32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    '{4'd14, 4'd10, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0},
    '{4'd15, 4'd10, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0},
    '{4'd15, 4'd3,  32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0},
    '{4'd15, 4'd3,  32'h00000001, 32'h00000000, 32'h00000001, 1'b0, 1'b0},
    '{4'd15, 4'd9,  32'h00000001, 32'h00000000, 32'h00000001, 1'b1, 1'b0},
    '{4'd15, 4'd9,  32'h00000001, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
    '{4'd15, 4'd11, 32'h00000001, 32'h00000000, 32'h00000001, 1'b1, 1'b0},
    '{4'd15, 4'd11, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    '{4'd6,  4'd6,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 1'b0},
    '{4'd6,  4'd6,  32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0},
    '{4'd6,  4'd6,  32'h10000000, 32'h10000000, 32'h20000000, 1'b1, 1'b0},
    '{4'd6,  4'd14, 32'h00000001, 32'h00000001, 32'h00000002, 1'b1, 1'b0},
    '{4'd15, 4'd1,  32'h2BAD2BAD, 32'h2BAD2BAD, 32'h00000000, 1'b1, 1'b0},
    '{4'd15, 4'd1,  32'h2BAD2BAD, 32'h00000001, 32'h2BAD2BAC, 1'b0, 1'b0},
    '{4'd0,  4'd0,  32'h00FF00FF, 32'h0F0F0F0F, 32'h0FFF0FFF, 1'b0, 1'b0},
    '{4'd1,  4'd0,  32'h00FF00FF, 32'h0F0F0F0F, 32'h000F000F, 1'b0, 1'b0},
    '{4'd8,  4'd0,  32'h00FF00FF, 32'h0F0F0F0F, 32'h0FF00FF0, 1'b0, 1'b0},
    '{4'd14, 4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
    '{4'd4,  4'd0,  32'h00000001, 32'h00000002, 32'h00000004, 1'b0, 1'b0},
    '{4'd4,  4'd0,  32'h00000001, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0},
    '{4'd8,  4'd0,  32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    '{4'd4,  4'd0,  32'h00000005, 32'h00000005, 32'h0000000B, 1'b0, 1'b0},
    '{4'd15, 4'd0,  32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0},
    '{4'd5,  4'd0,  32'h00000010, 32'h00000003, 32'h0000000C, 1'b0, 1'b0},
    '{4'd5,  4'd0,  32'h00000000, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0},
    '{4'd5,  4'd0,  32'h00000005, 32'h00000005, 32'hFFFFFFFF, 1'b0, 1'b0},
    '{4'd6,  4'd0,  32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    '{4'd5,  4'd0,  32'h00000005, 32'h00000005, 32'h00000000, 1'b0, 1'b0},
    '{4'd2,  4'd0,  32'h12345678, 32'h87654321, 32'h99999999, 1'b0, 1'b0},
    '{4'd12, 4'd0,  32'h00000001, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0},
    '{4'd12, 4'd0,  32'h00000003, 32'h00000004, 32'h00000007, 1'b0, 1'b0},
    '{4'd7,  4'd0,  32'h10000000, 32'h00000001, 32'h0FFFFFFF, 1'b0, 1'b0},
    '{4'd13, 4'd0,  32'h99999999, 32'h87654321, 32'h12345678, 1'b0, 1'b0},
    '{4'd13, 4'd0,  32'h00000000, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0},
    '{4'd14, 4'd12, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0},
    '{4'd14, 4'd12, 32'h00000001, 32'h00000001, 32'h00000002, 1'b1, 1'b0},
    '{4'd15, 4'd4,  32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b0},
    '{4'd10, 4'd0,  32'h00000005, 32'h00000006, 32'h00000000, 1'b0, 1'b1},
    '{4'd9,  4'd0,  32'h00000005, 32'h00000006, 32'h00000000, 1'b0, 1'b0},
    '{4'd11, 4'd0,  32'h00000005, 32'h00000006, 32'h00000000, 1'b0, 1'b0},
    '{4'd14, 4'd7,  32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    '{4'd15, 4'd8,  32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    '{4'd15, 4'd15, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    '{4'd15, 4'd0,  32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    '{4'd14, 4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
    '{4'd3,  4'd5,  32'h00000007, 32'h00000007, 32'h00000007, 1'b0, 1'b0},
    '{4'd4,  4'd0,  32'h00000000, 32'h00000000, 32'h00000001, 1'b0, 1'b0}
  };

  localparam string TAGS [NV] = '{
    "R6", "R6", "R4", "R4", "R4", "R4", "R7", "R7", "R7", "R7",
    "R9", "R9", "R8", "R8", "R9", "R9", "R10", "R10", "R10", "R10",
    "R8", "R8", "R1", "R1", "R1", "R2", "R3", "R3", "R3", "R3",
    "R2", "R3", "R3", "R3", "R3", "R3", "R2", "R2", "R2", "R2",
    "R2", "R2", "R6", "R6", "R6", "R12", "R12", "R12", "R11", "R11",
    "R11", "R11", "R2", "R4", "R4"
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] lhs = '0, rhs = '0;
  logic [3:0]   opcode = 4'd0, cond_sel = 4'd0;
  logic [W-1:0] result;
  logic         cond_out, field_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  eu_alu #(.W(W)) u_eu_alu (
    .clk(clk), .rst_n(rst_n), .lhs(lhs), .rhs(rhs), .opcode(opcode),
    .cond_sel(cond_sel), .result(result), .cond_out(cond_out),
    .field_sel(field_sel)
  );

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [3:0] sel,
                       input logic [W-1:0] l, input logic [W-1:0] r);
    opcode = op; cond_sel = sel; lhs = l; rhs = r;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R5: reset state
    repeat (3) @(negedge clk);
    chk("R5", "reset result", result, '0);
    chk("R5", "reset cond", {31'd0, cond_out}, '0);
    chk("R5", "reset field_sel", {31'd0, field_sel}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].sel, VECS[i].l, VECS[i].r);
      @(negedge clk);
      chk(TAGS[i], $sformatf("row %0d result", i), result, VECS[i].res);
      chk(TAGS[i], $sformatf("row %0d cond", i), {31'd0, cond_out}, {31'd0, VECS[i].cnd});
      chk(TAGS[i], $sformatf("row %0d field_sel", i), {31'd0, field_sel}, {31'd0, VECS[i].fu});
    end

    // R5: outputs hold until the next edge
    drive(4'd14, 4'd1, 32'h2, 32'h3);
    #2;
    chk("R5", "result before edge", result, 32'h1);
    @(negedge clk);
    chk("R5", "result after edge", result, 32'h5);

    // R5 and R3: reset mid-run clears outputs and flag
    drive(4'd14, 4'd0, 32'hFFFFFFFF, 32'h1);
    @(negedge clk);
    drive(4'd10, 4'd9, 32'h0, 32'h0);
    @(negedge clk);
    chk("R12", "field_sel before reset", {31'd0, field_sel}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R5", "async reset result", result, '0);
    chk("R5", "async reset field_sel", {31'd0, field_sel}, '0);
    drive(4'd0, 4'd0, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(4'd4, 4'd0, 32'h0, 32'h0);
    @(negedge clk);
    chk("R3", "flag cleared by reset", result, 32'h0);

    finish_run();
  end

endmodule